// File: doc/BRIEF.md
# Elastic Three-Stage Queue-Coupled Pipeline

This block carries data words through three fixed transform stages with no central controller. Four small queues separate the stages: an entry queue, two coupling queues and an exit queue. A stage moves a word whenever the queue in front of it holds something and the queue behind it can take one more. It then applies its transform to the head word, removes the word from the front queue and writes the result into the back queue. Words carry no valid tag. Whether a queue holds a word is the only record of data in flight.

The transforms are fixed. The first stage adds a constant, the second stage XORs with a mask, and the third stage rotates left by one bit. Upstream logic writes words with a valid/ready handshake, and downstream logic reads results with a second one.

A parameter selects how every queue behaves when it is full. A pass-through queue accepts a new word in the same cycle that a word leaves, even when full. A plain queue refuses new words whenever it is full. The two settings can be built side by side to compare throughput.

Top module: `elastic_pipe3`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Results leave in the order the inputs were accepted. Each result equals f3(f2(f1(x))), with DW=16, ADD_K=3 and XOR_K=0x5A5A. Here f1(x)=x+3 mod 2^16, f2(x)=x XOR 0x5A5A, and f3 rotates left by one bit (bit 15 moves to bit 0).
- R3: In an empty pipeline, a word accepted at one clock edge shows up on out_valid after the third following edge, so the latency is three edges.
- R4: Each stage fires on its own state alone, so with out_ready held low every queue fills. The block accepts exactly 4*DEPTH words (8 at default) and then holds in_ready low.
- R5: Under random out_ready, no word is lost or duplicated. While out_ready is low, out_valid stays high and out_data stays stable.
- R6: Pass-through setting: with input always offered and out_ready always high, a batch of 64 words leaves on 64 consecutive cycles.
- R7: Pass-through setting: a full queue accepts a word in the same cycle one leaves. From a completely full pipeline, raising out_ready makes in_ready high in that same cycle.
- R8: Plain setting: a full queue refuses a word even in a cycle where one leaves. From a completely full pipeline with out_ready held high, in_ready rises only after 4 cycles, one for each queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered |
| in_data | input | DW | Offered word |
| in_ready | output | 1 | Entry queue takes the word at this edge |
| out_valid | output | 1 | Exit queue holds a result |
| out_data | output | DW | Result at the head of the exit queue |
| out_ready | input | 1 | Downstream takes the result at this edge |

## Verification
The bench builds two copies of the block. Instance u0 uses the defaults: DW=16, DEPTH=2 and the pass-through queue setting. A second instance uses the same widths with the plain queue setting. The first copy gives access to one-word-per-cycle streaming, the same-cycle refill of a full pipeline, and random back-pressure against a scoreboard. The second copy shows the four-cycle delay before a plain-queue pipeline accepts input again after being full, with the same word values and ordering.

// File: rtl/ep_pkg.sv
package ep_pkg;
   // Queue behaviour when full: pass lets a same-cycle read free the slot.
   typedef enum logic [0:0] {
      QK_PASS  = 1'b0,
      QK_PLAIN = 1'b1
   } qkind_e;

   localparam int NUM_STAGES = 3;
   localparam int NUM_QUEUES = NUM_STAGES + 1;
endpackage

// File: rtl/ep_fifo.sv
module ep_fifo #(
   parameter int             DW    = 16,
   parameter int             DEPTH = 2,
   parameter ep_pkg::qkind_e KIND  = ep_pkg::QK_PASS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enq_valid,
   input  logic [DW-1:0] enq_data,
   output logic          enq_ready,
   output logic          deq_valid,
   output logic [DW-1:0] deq_data,
   input  logic          deq_ready
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST_IX = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   initial begin
      assert (DW >= 2) else $error("ep_fifo: DW must be at least 2");
      assert (DEPTH >= 2) else $error("ep_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ix, rd_ix;
   logic [CW-1:0] fill;
   logic          full, empty, enq_fire, deq_fire;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] ix);
      return (ix == LAST_IX) ? '0 : ix + AW'(1);
   endfunction

   assign full      = (fill == FULL_CNT);
   assign empty     = (fill == '0);
   assign deq_valid = !empty;
   assign deq_data  = mem[rd_ix];
   assign deq_fire  = deq_valid && deq_ready;
   assign enq_fire  = enq_valid && enq_ready;

   generate
      if (KIND == ep_pkg::QK_PASS) begin : g_pass
         assign enq_ready = !full || deq_fire;

         // R7: full, read and write together -> stays full
         p_full_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (full && deq_fire && enq_valid) |=> full);
      end else begin : g_plain
         assign enq_ready = !full;

         // R8: full queue that is read loses one word, no refill
         p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (full && deq_fire) |=> !full);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (enq_fire) mem[wr_ix] <= enq_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ix <= '0;
         rd_ix <= '0;
         fill  <= '0;
      end else begin
         if (enq_fire) wr_ix <= step(wr_ix);
         if (deq_fire) rd_ix <= step(rd_ix);
         case ({enq_fire, deq_fire})
            2'b10:   fill <= fill + CW'(1);
            2'b01:   fill <= fill - CW'(1);
            default: fill <= fill;
         endcase
      end
   end

   // R5: a head word that is not taken stays put
   p_hold_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_data)));
endmodule

// File: rtl/ep_stage.sv
module ep_stage #(
   parameter int            DW    = 16,
   parameter int            SEL   = 0,
   parameter logic [DW-1:0] ADD_V = '0,
   parameter logic [DW-1:0] XOR_V = '0
) (
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          in_ready,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   input  logic          out_ready
);
   initial begin
      assert (SEL >= 0 && SEL <= 2) else $error("ep_stage: SEL out of range");
   end

   // Fires when the front queue holds a word and the back queue can take one.
   assign out_valid = in_valid;
   assign in_ready  = out_ready;

   generate
      if (SEL == 0) begin : g_add
         assign out_data = in_data + ADD_V;
      end else if (SEL == 1) begin : g_xor
         assign out_data = in_data ^ XOR_V;
      end else begin : g_rot
         assign out_data = {in_data[DW-2:0], in_data[DW-1]};
      end
   endgenerate
endmodule

// File: rtl/elastic_pipe3.sv
module elastic_pipe3 #(
   parameter int             DW    = 16,
   parameter int             DEPTH = 2,
   parameter ep_pkg::qkind_e KIND  = ep_pkg::QK_PASS,
   parameter int unsigned    ADD_K = 3,
   parameter int unsigned    XOR_K = 'h5A5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          in_ready,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   input  logic          out_ready
);
   localparam int NQ = ep_pkg::NUM_QUEUES;
   localparam int NS = ep_pkg::NUM_STAGES;
   localparam logic [DW-1:0] ADD_V = DW'(ADD_K);
   localparam logic [DW-1:0] XOR_V = DW'(XOR_K);

   initial begin
      assert (DW >= 2) else $error("elastic_pipe3: DW must be at least 2");
      assert (DEPTH >= 2) else $error("elastic_pipe3: DEPTH must be at least 2");
   end

   logic [NQ-1:0]         qe_v, qe_r, qd_v, qd_r;
   logic [NQ-1:0][DW-1:0] qe_d, qd_d;
   logic                  last_fire;

   assign qe_v[0]    = in_valid;
   assign qe_d[0]    = in_data;
   assign in_ready   = qe_r[0];
   assign out_valid  = qd_v[NQ-1];
   assign out_data   = qd_d[NQ-1];
   assign qd_r[NQ-1] = out_ready;

   generate
      for (genvar q = 0; q < NQ; q++) begin : g_q
         ep_fifo #(.DW(DW), .DEPTH(DEPTH), .KIND(KIND)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .enq_valid (qe_v[q]),
            .enq_data  (qe_d[q]),
            .enq_ready (qe_r[q]),
            .deq_valid (qd_v[q]),
            .deq_data  (qd_d[q]),
            .deq_ready (qd_r[q])
         );
      end
      for (genvar s = 0; s < NS; s++) begin : g_s
         ep_stage #(.DW(DW), .SEL(s), .ADD_V(ADD_V), .XOR_V(XOR_V)) u_st (
            .in_valid  (qd_v[s]),
            .in_data   (qd_d[s]),
            .in_ready  (qd_r[s]),
            .out_valid (qe_v[s+1]),
            .out_data  (qe_d[s+1]),
            .out_ready (qe_r[s+1])
         );
      end
   endgenerate

   assign last_fire = qd_v[NQ-2] && qd_r[NQ-2];

   // R3: a result can only appear after the last stage has fired
   p_result_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(last_fire));
endmodule

// File: tb/sim_elastic_pipe3.sv
module sim_elastic_pipe3;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
   logic [15:0] in_data = '0, out_data;
   logic        in1_valid = 1'b0, in1_ready, out1_valid, out1_ready = 1'b0;
   logic [15:0] in1_data = '0, out1_data;

   elastic_pipe3 u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready)
   );

   elastic_pipe3 #(.KIND(ep_pkg::QK_PLAIN)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in1_valid), .in_data(in1_data),
      .in_ready(in1_ready), .out_valid(out1_valid), .out_data(out1_data),
      .out_ready(out1_ready)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   int bp_mode = 0;
   int out_cnt = 0, first_cyc = 0, last_cyc = 0;
   logic [15:0] exp_q[$];
   logic [15:0] exp1_q[$];
   logic [15:0] e0, e1;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] model(input logic [15:0] x);
      logic [15:0] a, b;
      a = x + 16'd3;
      b = a ^ 16'h5A5A;
      return {b[14:0], b[15]};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor for u0: drives back-pressure, then compares accepted results.
   always @(negedge clk) begin
      case (bp_mode)
         0:       out_ready = 1'b1;
         1:       out_ready = ($urandom % 3) != 0;
         default: out_ready = 1'b0;
      endcase
      #1;
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) chk(1'b0, "R2 unexpected result", out_data, 0);
         else begin
            e0 = exp_q.pop_front();
            chk(out_data == e0, "R2 result value/order", out_data, e0);
         end
         if (out_cnt == 0) first_cyc = cyc;
         last_cyc = cyc;
         out_cnt++;
      end
   end

   // Monitor for u1.
   always @(negedge clk) begin
      #1;
      if (rst_n && out1_valid && out1_ready) begin
         if (exp1_q.size() == 0) chk(1'b0, "R8 unexpected result", out1_data, 0);
         else begin
            e1 = exp1_q.pop_front();
            chk(out1_data == e1, "R8 result value/order (R2)", out1_data, e1);
         end
      end
   end

   task automatic push(input logic [15:0] x);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x;
      #2;
      while (!in_ready) begin
         @(negedge clk);
         #2;
      end
      exp_q.push_back(model(x));
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic try_push(input logic [15:0] x, output bit ok);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x;
      #2;
      ok = in_ready;
      if (ok) exp_q.push_back(model(x));
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic try_push1(input logic [15:0] x, output bit ok);
      @(negedge clk);
      in1_valid = 1'b1;
      in1_data  = x;
      #2;
      ok = in1_ready;
      if (ok) exp1_q.push_back(model(x));
      @(posedge clk);
      #1 in1_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < 3000 && (exp_q.size() != 0 || exp1_q.size() != 0); i++)
         @(posedge clk);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
      chk(exp1_q.size() == 0, req, exp1_q.size(), 0);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      bit ok;
      int n, acc;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      #3;
      chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
      chk(out1_valid == 1'b0, "R1 plain out_valid after reset", out1_valid, 0);

      // R3 latency through an empty pipeline
      bp_mode = 0;
      push(16'h0011);
      n = 0;
      do begin
         @(negedge clk);
         #3;
         if (!out_valid) n++;
      end while (!out_valid && n < 10);
      chk(n == 3, "R3 latency edges", n, 3);
      drain("R2 drain after latency test");

      // R6 streaming throughput
      out_cnt = 0;
      for (int i = 0; i < 64; i++) push(16'(i * 37 + 5));
      drain("R6 drain after stream");
      chk(out_cnt == 64, "R6 results in stream", out_cnt, 64);
      chk(last_cyc - first_cyc == 63, "R6 consecutive output cycles", last_cyc - first_cyc, 63);

      // R4 capacity with output stalled
      bp_mode = 2;
      @(posedge clk);
      acc = 0;
      for (int i = 0; i < 16; i++) begin
         try_push(16'hF000 + 16'(i), ok);
         if (ok) acc++;
      end
      chk(acc == 8, "R4 words absorbed while stalled", acc, 8);
      @(negedge clk);
      #3;
      chk(in_ready == 1'b0, "R4 in_ready low when full", in_ready, 0);

      // R7 same-cycle refill of a full pipeline
      bp_mode = 0;
      try_push(16'hBEEF, ok);
      chk(ok == 1'b1, "R7 in_ready with out_ready in same cycle", ok, 1);
      drain("R2 drain after full pipeline");

      // R5 random back-pressure
      bp_mode = 1;
      out_cnt = 0;
      for (int i = 0; i < 200; i++) push(16'($urandom));
      drain("R5 drain under random back-pressure");
      chk(out_cnt == 200, "R5 results under random back-pressure", out_cnt, 200);
      bp_mode = 0;

      // R8 plain queues: fill, then time the return of in_ready
      out1_ready = 1'b0;
      acc = 0;
      for (int i = 0; i < 16; i++) begin
         try_push1(16'h0A00 + 16'(i), ok);
         if (ok) acc++;
      end
      chk(acc == 8, "R4 plain words absorbed while stalled", acc, 8);
      @(negedge clk);
      out1_ready = 1'b1;
      in1_valid  = 1'b1;
      in1_data   = 16'h1234;
      n = 0;
      #2;
      while (!in1_ready && n < 20) begin
         n++;
         @(negedge clk);
         #2;
      end
      chk(n == 4, "R8 cycles until plain pipeline accepts", n, 4);
      exp1_q.push_back(model(16'h1234));
      @(posedge clk);
      #1 in1_valid = 1'b0;
      drain("R8 drain plain pipeline");

      finish_run();
   end
endmodule